// File: doc/BRIEF.md
# Four-Mode SPI Master Controller

This block is a single-master serial peripheral interface controller that moves one byte in each direction per frame. A system-side client places a byte on the transmit input and pulses a start strobe. The controller then lowers the active-low select, runs eight clock pulses on the serial clock, shifts its byte out most significant bit first and shifts the returning byte in. It raises the select again, presents the received byte and pulses a done flag.

A two-bit mode input chooses the clock polarity and phase, so the block can talk to a device in any of the four common modes. The upper bit sets the level the serial clock rests at, and the lower bit chooses whether a pulse's first or second edge latches incoming data. An optional receive-phase override lets the input line be sampled on a different edge from the one the output line is timed to. The serial clock is derived from the system clock through a half-period divider that can be changed between frames.

Top module: `spi4_master`

## Requirements
- R1: Mode bit 1 is the clock polarity. Whenever no frame runs, `sclk_o` equals the value `mode_i[1]` had one cycle earlier, and inside a frame it starts and ends at the latched polarity.
- R2: With mode bit 0 (clock phase) clear, bit 7 of the transmit byte is on `mosi_o` from the cycle `cs_n_o` falls. MOSI changes only on trailing edges, and MISO is latched on leading edges. A device that changes MISO on leading edges therefore arrives shifted right by one, with 0 as the new top bit.
- R3: With the clock phase set, MOSI changes on leading edges and MISO is latched on trailing edges.
- R4: Each frame is full duplex and MSB first. `rx_byte_o` takes the eight latched MISO bits in the cycle `done_o` is high and holds its value at all other times. The device receives exactly `tx_byte_i`. This holds in all four modes.
- R5: Framing: with half-period H, the first clock edge comes H cycles after `cs_n_o` falls and the select rises H cycles after the last edge. The select stays low for 17·H cycles, and exactly 16 clock transitions (8 pulses) occur while it is low.
- R6: A half-period lasts `half_div_i` system clocks, sampled at start. A value of 0 is treated as 1.
- R7: Mode, receive override and divider are captured when a frame starts. Changing them during the frame has no effect on that frame.
- R8: A start pulse while `busy_o` is high is ignored: no extra frame, and the running frame is unaffected.
- R9: `busy_o` is high from the cycle after an accepted start until the select rises. `done_o` is high for exactly one cycle, which is the first cycle with `cs_n_o` high again.
- R10: When `rx_split_i` is 1 at start, MISO is latched by the phase in `rx_cpha_i` instead of mode bit 0. MOSI timing is unchanged.
- R11: After reset, `cs_n_o` is 1, `busy_o` and `done_o` are 0, `sclk_o` is 0 and `rx_byte_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Clock mode: bit 1 polarity, bit 0 phase |
| rx_split_i | input | 1 | Use `rx_cpha_i` as the receive phase |
| rx_cpha_i | input | 1 | Receive phase when the override is on |
| half_div_i | input | DIV_W | System clocks per serial half-period (0 acts as 1) |
| start_i | input | 1 | Begin a frame when idle |
| tx_byte_i | input | DATA_W | Byte to transmit |
| rx_byte_o | output | DATA_W | Last received byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low select |

## Verification
The bench builds the block with its default 8-bit word and 8-bit divider field. It drives half-periods of 0, 1, 2 and 3 system clocks. The zero and one settings reach the clamp and the fastest case, where every cycle is an edge. The settings of 2 and 3 make the select setup and hold windows measurably wider than a single cycle. A device model with its own independent polarity and phases checks every mode. It also runs the split-phase receive in both directions and a deliberate phase mismatch whose shifted result is known in advance.

// File: rtl/spi4_pkg.sv
package spi4_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } spi_state_e;

  typedef struct packed {
    logic cpol;
    logic tx_cpha;
    logic rx_cpha;
  } spi_cfg_t;

endpackage

// File: rtl/spi4_halfper_timer.sv
module spi4_halfper_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] reload;

  // zero is clamped to a one-cycle half-period
  always_comb begin
    if (half_i == '0) reload = '0;
    else              reload = half_i - DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run_i || cnt_q == '0) begin
      cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign tick_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/spi4_phase_ctrl.sv
module spi4_phase_ctrl
  import spi4_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             rx_split_i,
  input  logic             rx_cpha_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             start_i,
  input  logic             tick_i,
  output logic [DIV_W-1:0] half_o,
  output logic             load_o,
  output logic             drive_o,
  output logic             sample_o,
  output logic             finish_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             cs_n_o
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_E = EW'(EDGES - 1);

  spi_state_e       state_q;
  spi_cfg_t         cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [EW-1:0]    ecnt_q;
  logic             sclk_q;
  logic             cs_n_q;
  logic             done_q;

  logic [EW-1:0]    e_idx;
  logic             lead;
  logic             edge_now;
  logic             last_e;

  always_comb begin
    e_idx    = (state_q == ST_LEAD) ? '0 : ecnt_q;
    lead     = ~e_idx[0];
    last_e   = (e_idx == LAST_E);
    edge_now = tick_i && (state_q == ST_LEAD || state_q == ST_SHIFT);
  end

  // leading edges are even indices, trailing edges odd
  assign sample_o = edge_now && (lead ^ cfg_q.rx_cpha);
  assign drive_o  = edge_now && (lead == cfg_q.tx_cpha) && (e_idx != '0) && !last_e;
  assign load_o   = start_i && (state_q == ST_IDLE);
  assign finish_o = tick_i && (state_q == ST_TAIL);
  assign half_o   = (state_q == ST_IDLE) ? half_div_i : div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      div_q   <= '0;
      ecnt_q  <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sclk_q <= mode_i[1];
          if (start_i) begin
            cfg_q.cpol    <= mode_i[1];
            cfg_q.tx_cpha <= mode_i[0];
            cfg_q.rx_cpha <= rx_split_i ? rx_cpha_i : mode_i[0];
            div_q         <= half_div_i;
            ecnt_q        <= '0;
            cs_n_q        <= 1'b0;
            state_q       <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick_i) begin
            sclk_q  <= ~sclk_q;
            ecnt_q  <= EW'(1);
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick_i) begin
            sclk_q <= ~sclk_q;
            if (last_e) begin
              ecnt_q  <= '0;
              state_q <= ST_TAIL;
            end else begin
              ecnt_q <= ecnt_q + EW'(1);
            end
          end
        end
        ST_TAIL: begin
          if (tick_i) begin
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign sclk_o = sclk_q;
  assign cs_n_o = cs_n_q;

endmodule

// File: rtl/spi4_shift_unit.sv
module spi4_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              drive_i,
  input  logic              sample_i,
  input  logic              finish_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_byte_o
);

  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] rx_sh_q;
  logic [DATA_W-1:0] rx_q;
  logic              mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh_q <= '0;
      mosi_q  <= 1'b0;
    end else if (load_i) begin
      tx_sh_q <= tx_byte_i;
      mosi_q  <= tx_byte_i[DATA_W-1];
    end else if (drive_i) begin
      tx_sh_q <= tx_sh_q << 1;
      mosi_q  <= tx_sh_q[DATA_W-2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh_q <= '0;
    end else if (sample_i) begin
      rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
    end else if (finish_i) begin
      rx_q <= rx_sh_q;
    end
  end

  assign mosi_o    = mosi_q;
  assign rx_byte_o = rx_q;

endmodule

// File: rtl/spi4_master.sv
module spi4_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              rx_split_i,
  input  logic              rx_cpha_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o
);

  logic [DIV_W-1:0] half_sel;
  logic             tick;
  logic             load;
  logic             drive;
  logic             sample;
  logic             finish;

  spi4_halfper_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (busy_o),
    .half_i (half_sel),
    .tick_o (tick)
  );

  spi4_phase_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .rx_split_i (rx_split_i),
    .rx_cpha_i  (rx_cpha_i),
    .half_div_i (half_div_i),
    .start_i    (start_i),
    .tick_i     (tick),
    .half_o     (half_sel),
    .load_o     (load),
    .drive_o    (drive),
    .sample_o   (sample),
    .finish_o   (finish),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sclk_o     (sclk_o),
    .cs_n_o     (cs_n_o)
  );

  spi4_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .tx_byte_i (tx_byte_i),
    .drive_i   (drive),
    .sample_i  (sample),
    .finish_i  (finish),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_byte_o (rx_byte_o)
  );

endmodule

// File: rtl/spi4_master_chk.sv
module spi4_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_i,
  input logic [DATA_W-1:0] rx_byte_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              sclk_o,
  input logic              mosi_o,
  input logic              cs_n_o
);

  // R1: idle clock follows the polarity bit
  p_idle_level_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !busy_o && !$past(busy_o)) |-> (sclk_o == $past(mode_i[1])));

  // R2 / R3: MOSI moves only together with a clock edge inside a frame
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && !$past(cs_n_o) && $stable(sclk_o)) |-> $stable(mosi_o));

  // R4: received byte changes only with done
  p_rx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(rx_byte_o));

  // R9: selected implies busy
  p_busy_selected_r9: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> busy_o);

  // R9: done lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: done marks the first deselected cycle
  p_done_at_release_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cs_n_o && !$past(cs_n_o)));

endmodule

bind spi4_master spi4_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_i    (mode_i),
  .rx_byte_o (rx_byte_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .sclk_o    (sclk_o),
  .mosi_o    (mosi_o),
  .cs_n_o    (cs_n_o)
);

// File: tb/sim_spi4_master.sv
`timescale 1ns/1ps
module sim_spi4_master;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic       rx_split_i = 1'b0;
  logic       rx_cpha_i = 1'b0;
  logic [7:0] half_div_i = 8'd1;
  logic       start_i = 1'b0;
  logic [7:0] tx_byte_i = 8'd0;
  logic [7:0] rx_byte_o;
  logic       busy_o, done_o, sclk_o, mosi_o, cs_n_o;
  logic       miso = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi4_master u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .rx_split_i(rx_split_i),
    .rx_cpha_i(rx_cpha_i), .half_div_i(half_div_i), .start_i(start_i),
    .tx_byte_i(tx_byte_i), .rx_byte_o(rx_byte_o), .busy_o(busy_o),
    .done_o(done_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso),
    .cs_n_o(cs_n_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // device model and frame monitor
  logic       s_cpol = 0, s_mosi_cpha = 0, s_miso_cpha = 0;
  logic [7:0] s_tx = 0, s_rx = 0;
  int         di = 0;
  logic       prev_cs = 1, prev_sclk = 0;
  int         t_fall = 0, t_last = 0, toggles = 0, first_edge = -1;
  int         frame_len = 0, tail_len = 0, frames = 0, done_cnt = 0;
  logic       lvl_fall = 0, lvl_rise = 0, mosi_fall = 0, done_rise = 0;
  logic [7:0] rx_at_done = 0;

  always @(negedge clk) begin
    if (done_o) done_cnt = done_cnt + 1;
    if (prev_cs && !cs_n_o) begin
      t_fall = cyc; toggles = 0; first_edge = -1;
      lvl_fall = sclk_o; mosi_fall = mosi_o; s_rx = 0;
      if (!s_miso_cpha) begin miso = s_tx[7]; di = 6; end
      else di = 7;
    end else if (!cs_n_o && sclk_o != prev_sclk) begin
      logic lead;
      lead = (sclk_o != s_cpol);
      toggles = toggles + 1;
      if (first_edge < 0) first_edge = cyc - t_fall;
      t_last = cyc;
      if (lead ^ s_mosi_cpha) s_rx = {s_rx[6:0], mosi_o};
      if ((lead == s_miso_cpha) && di >= 0) begin miso = s_tx[di]; di = di - 1; end
    end else if (!prev_cs && cs_n_o) begin
      frame_len = cyc - t_fall; tail_len = cyc - t_last;
      lvl_rise = sclk_o; done_rise = done_o; rx_at_done = rx_byte_o;
      miso = 1'b0;
      frames = frames + 1;
    end
    prev_cs = cs_n_o; prev_sclk = sclk_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] m, input logic split, input logic rph,
                           input logic [7:0] h, input logic [7:0] tx,
                           input logic scpol, input logic smo, input logic smi,
                           input logic [7:0] stx);
    int f0;
    s_cpol = scpol; s_mosi_cpha = smo; s_miso_cpha = smi; s_tx = stx;
    f0 = frames;
    @(negedge clk);
    mode_i = m; rx_split_i = split; rx_cpha_i = rph; half_div_i = h;
    tx_byte_i = tx;
    repeat (2) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (frames == f0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 cs_n", cs_n_o, 1);
    chk("R11 busy", busy_o, 0);
    chk("R11 done", done_o, 0);
    chk("R11 sclk", sclk_o, 0);
    chk("R11 rx", rx_byte_o, 0);
  endtask

  task automatic t_idle_level();
    @(negedge clk); mode_i = 2'd2;
    repeat (2) @(negedge clk);
    chk("R1 idle high", sclk_o, 1);
    mode_i = 2'd1;
    repeat (2) @(negedge clk);
    chk("R1 idle low", sclk_o, 0);
  endtask

  task automatic t_modes();
    for (int hh = 1; hh <= 3; hh += 2) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] tx, stx, h;
        int d0;
        tx = 8'hA5 ^ 8'(m * 17 + hh); stx = 8'h3C + 8'(m * 29 + hh); h = 8'(hh);
        d0 = done_cnt;
        run_frame(2'(m), 0, 0, h, tx, m[1], m[0], m[0], stx);
        chk("R4 rx byte", rx_at_done, stx);
        chk("R4 device got tx", s_rx, tx);
        chk(m[0] ? "R3 phase1 data" : "R2 phase0 data", rx_at_done, stx);
        chk("R5 toggles", toggles, 16);
        chk("R5 frame length", frame_len, 17 * hh);
        chk("R5 setup", first_edge, hh);
        chk("R5 hold", tail_len, hh);
        chk("R1 level at fall", lvl_fall, m[1]);
        chk("R1 level at rise", lvl_rise, m[1]);
        chk("R9 done at release", done_rise, 1);
        chk("R9 one done", done_cnt - d0, 1);
        if (!m[0]) chk("R2 msb at select", mosi_fall, tx[7]);
      end
    end
  endtask

  task automatic t_mismatch();
    run_frame(2'd0, 0, 0, 8'd2, 8'h5A, 0, 0, 1, 8'hC3);
    chk("R2 leading-edge mismatch shift", rx_at_done, 8'h61);
  endtask

  task automatic t_split();
    run_frame(2'd0, 1, 1, 8'd2, 8'h96, 0, 0, 1, 8'h4D);
    chk("R10 split rx", rx_at_done, 8'h4D);
    chk("R10 tx kept", s_rx, 8'h96);
    run_frame(2'd3, 1, 0, 8'd1, 8'h1E, 1, 1, 0, 8'hE7);
    chk("R10 split rx mode3", rx_at_done, 8'hE7);
    chk("R10 tx kept mode3", s_rx, 8'h1E);
  endtask

  task automatic t_latched();
    int f0;
    s_cpol = 0; s_mosi_cpha = 1; s_miso_cpha = 1; s_tx = 8'hB2;
    f0 = frames;
    @(negedge clk);
    mode_i = 2'd1; rx_split_i = 0; half_div_i = 8'd2; tx_byte_i = 8'h6C;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    repeat (3) @(negedge clk);
    mode_i = 2'd2; rx_split_i = 1; rx_cpha_i = 0; half_div_i = 8'd5;
    while (frames == f0) @(negedge clk);
    chk("R7 rx unaffected", rx_at_done, 8'hB2);
    chk("R7 tx unaffected", s_rx, 8'h6C);
    chk("R7 polarity kept", lvl_rise, 0);
    chk("R7 divider kept", frame_len, 34);
    @(negedge clk); rx_split_i = 0;
  endtask

  task automatic t_busy_start();
    int f0;
    s_cpol = 0; s_mosi_cpha = 0; s_miso_cpha = 0; s_tx = 8'h0F;
    f0 = frames;
    @(negedge clk);
    mode_i = 2'd0; half_div_i = 8'd2; tx_byte_i = 8'hA3;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    chk("R9 busy after start", busy_o, 1);
    repeat (10) @(negedge clk);
    tx_byte_i = 8'hFF; start_i = 1;
    @(negedge clk); start_i = 0;
    while (frames == f0) @(negedge clk);
    chk("R8 tx intact", s_rx, 8'hA3);
    chk("R8 length intact", frame_len, 34);
    repeat (6) @(negedge clk);
    chk("R8 no extra frame", frames - f0, 1);
    chk("R8 stays deselected", cs_n_o, 1);
    chk("R9 busy cleared", busy_o, 0);
  endtask

  task automatic t_div0();
    run_frame(2'd2, 0, 0, 8'd0, 8'h81, 1, 0, 0, 8'h7E);
    chk("R6 zero clamps length", frame_len, 17);
    chk("R6 zero clamps setup", first_edge, 1);
    chk("R6 data", rx_at_done, 8'h7E);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_level();
    t_modes();
    t_mismatch();
    t_split();
    t_latched();
    t_busy_start();
    t_div0();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule